// File: doc/BRIEF.md
# Sound Channel Timer and Tone Generator

This block is the rate engine of one audio voice. A 16-bit up-counter advances on every second system clock. When it wraps past its all-ones value it is loaded from a programmable reload register, and the voice moves on by one sample step. Software picks the sample rate by writing the two's-complement negative of (half the system clock / desired rate) into the reload register.

Each step moves a tone generator forward. In square mode, an eight-position pattern with a programmable number of high positions gives a rectangular wave at one eighth of the step rate. In noise mode, a 15-bit linear feedback shift register produces one new pseudo-random level per step. Levels are not interpolated: the voice holds its level from one step to the next.

A free-running divider captures the voice level every 1024 system clocks, with an optional 10-bit truncation, and presents it to a downstream mixer on a valid/ready stream. The capture rate is fixed and cannot be stalled. Back-pressure therefore never holds up the voice. While `out_valid` is high and `out_ready` is low, `out_data` holds still. The next capture then replaces any sample that was not accepted.

Top module: `snd_chan_core`

## Requirements
- R1: While the voice runs with a reload value R written before the last start, consecutive `step_pulse` cycles are exactly 2*(65536-R) clocks apart.
- R2: A reload write while the voice is stopped also loads the counter, so the first `step_pulse` after the following start edge comes 2*(65536-R)-1 or 2*(65536-R) clocks after that edge.
- R3: While the voice is stopped, `step_pulse` stays low and the counter holds its value, so restarting without a new write resumes from where counting stopped.
- R4: In square mode, the step index is cleared on a start edge and advances by one, modulo 8, on each step. With H = `duty` (a `duty` of 0 counts as 1), index values 0 to H-1 give level 16'h7FFF and the others give 16'h8001.
- R5: In noise mode, the 15-bit shift register is set to all ones on a start edge. On each step it shifts right, and its new top bit is the XOR of its two lowest bits. A lowest bit of 1 gives level 16'h8001, and 0 gives 16'h7FFF.
- R6: A stopped voice has level 0. A running voice holds its level unchanged between steps.
- R7: A capture happens at the 1024th rising clock edge after reset release and every 1024 edges after that. It takes the level and mode inputs as they were just before that edge.
- R8: With `trunc_en` high at a capture, the six low bits of the captured sample are cleared.
- R9: A capture raises `out_valid`. `out_valid` falls on the edge after a cycle in which `out_valid` and `out_ready` are both high and no capture occurs. While `out_valid` is high and no capture occurs, `out_data` is stable.
- R10: During reset, `out_valid` and `step_pulse` are low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_start | input | 1 | Run level; a low-to-high change seen at a clock edge is a start edge |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_val | input | 16 | Reload value (negative of half clock / sample rate) |
| noise_sel | input | 1 | 0 selects square mode, 1 selects noise mode |
| duty | input | 3 | Number of high positions out of eight in square mode |
| trunc_en | input | 1 | Clear the six low bits of captured samples |
| step_pulse | output | 1 | High for one cycle after each sample step |
| out_valid | output | 1 | A captured sample is waiting |
| out_ready | input | 1 | Mixer accepts the sample |
| out_data | output | 16 | Captured signed level |

## Verification
A step and the generator's move to its new index or register value take effect on the same edge. `step_pulse` is therefore visible in the cycle right after the wrapping edge. A capture uses the level from before its edge, and the sample shows on `out_data` in the cycle after that edge. The bench drives inputs just after a rising edge and samples at the falling edge. It keeps a model of the step index, shift register and run state, checks each capture against the model state from the previous sample point, and only then applies the step it has just seen. Step spacing is counted in falling edges from the start edge. The first interval may land on either of two cycles because of the half-rate phase.

// File: rtl/snd_chan_pkg.sv
package snd_chan_pkg;
  typedef enum logic {
    WAVE_SQUARE = 1'b0,
    WAVE_NOISE  = 1'b1
  } wave_e;

  localparam int SND_TMR_W       = 16;
  localparam int SND_DATA_W      = 16;
  localparam int SND_STEP_W      = 3;
  localparam int SND_LFSR_W      = 15;
  localparam int SND_STROBE_PER  = 1024;
  localparam int SND_KEEP_BITS   = 10;
endpackage

// File: rtl/snd_step_timer.sv
module snd_step_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload_wr,
  input  logic [TMR_W-1:0] reload_val,
  output logic             wrap,
  output logic             step_q
);
  localparam logic [TMR_W-1:0] CNT_TOP = '1;

  logic             half_q;
  logic             tick;
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] rld_q;

  assign tick = half_q & run;
  assign wrap = tick && (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      step_q <= 1'b0;
      cnt_q  <= '0;
      rld_q  <= '0;
    end else begin
      half_q <= ~half_q;
      step_q <= wrap;
      if (reload_wr) rld_q <= reload_val;
      if (reload_wr && !run) cnt_q <= reload_val;
      else if (wrap)         cnt_q <= rld_q;
      else if (tick)         cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(rld_q)); // R1
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload_wr) |=> cnt_q == $past(cnt_q)); // R3
  AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !step_q); // R3
endmodule

// File: rtl/snd_psg_gen.sv
module snd_psg_gen
  import snd_chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STEP_W = 3,
  parameter int LFSR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              advance,
  input  wave_e             wave,
  input  logic [STEP_W-1:0] duty,
  output logic [DATA_W-1:0] level
);
  localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-2){1'b0}}, 1'b1};
  localparam logic [LFSR_W-1:0] SEED   = '1;

  logic [STEP_W-1:0] idx_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [STEP_W-1:0] high_cnt;
  logic              sq_high;

  assign high_cnt = (duty == '0) ? STEP_W'(1) : duty;
  assign sq_high  = (idx_q < high_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      lfsr_q <= SEED;
    end else if (start) begin
      idx_q  <= '0;
      lfsr_q <= SEED;
    end else if (advance) begin
      idx_q  <= idx_q + 1'b1;
      lfsr_q <= {lfsr_q[0] ^ lfsr_q[1], lfsr_q[LFSR_W-1:1]};
    end
  end

  always_comb begin
    if (!run)                    level = '0;
    else if (wave == WAVE_NOISE) level = lfsr_q[0] ? NEG_FS : POS_FS;
    else                         level = sq_high ? POS_FS : NEG_FS;
  end

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> idx_q == '0); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start) |=> idx_q == $past(idx_q) + 1'b1); // R4
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R5
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !advance && !start) |=> (run |-> $stable(idx_q))); // R6
endmodule

// File: rtl/snd_out_strobe.sv
module snd_out_strobe #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] div_q;

  assign strobe = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (strobe) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R7
endmodule

// File: rtl/snd_chan_core.sv
module snd_chan_core
  import snd_chan_pkg::*;
#(
  parameter int TMR_W     = SND_TMR_W,
  parameter int DATA_W    = SND_DATA_W,
  parameter int STEP_W    = SND_STEP_W,
  parameter int LFSR_W    = SND_LFSR_W,
  parameter int STROBE_P  = SND_STROBE_PER,
  parameter int KEEP_BITS = SND_KEEP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_start,
  input  logic              reload_wr,
  input  logic [TMR_W-1:0]  reload_val,
  input  logic              noise_sel,
  input  logic [STEP_W-1:0] duty,
  input  logic              trunc_en,
  output logic              step_pulse,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int DROP_BITS = DATA_W - KEEP_BITS;

  logic              run_q;
  logic              start_edge;
  logic              wrap;
  logic              strobe;
  logic [DATA_W-1:0] level;
  logic [DATA_W-1:0] cut_mask;
  logic [DATA_W-1:0] sample;
  wave_e             wave;

  assign start_edge = ch_start & ~run_q;
  assign wave       = noise_sel ? WAVE_NOISE : WAVE_SQUARE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= ch_start;
  end

  snd_step_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .reload_wr  (reload_wr),
    .reload_val (reload_val),
    .wrap       (wrap),
    .step_q     (step_pulse)
  );

  snd_psg_gen #(.DATA_W(DATA_W), .STEP_W(STEP_W), .LFSR_W(LFSR_W)) u_psg (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_edge),
    .run     (run_q),
    .advance (wrap),
    .wave    (wave),
    .duty    (duty),
    .level   (level)
  );

  snd_out_strobe #(.PERIOD(STROBE_P)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe)
  );

  generate
    if (DROP_BITS > 0) begin : g_cut
      assign cut_mask = {{KEEP_BITS{1'b1}}, {DROP_BITS{1'b0}}};
    end else begin : g_nocut
      assign cut_mask = '1;
    end
  endgenerate

  assign sample = trunc_en ? (level & cut_mask) : level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (strobe) begin
      out_valid <= 1'b1;
      out_data  <= sample;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !strobe) |=> (out_valid && $stable(out_data))); // R9
  AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> out_valid); // R7
  AST_TRUNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && trunc_en) |=> (out_data & ~cut_mask) == '0); // R8
  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !run_q) |=> out_data == '0); // R6
endmodule

// File: tb/snd_chan_core_bench.sv
module snd_chan_core_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, ch_start, reload_wr, noise_sel, trunc_en, out_ready;
  logic [15:0] reload_val;
  logic [2:0]  duty;
  logic        step_pulse, out_valid;
  logic [15:0] out_data;

  snd_chan_core u_snd_chan_core (
    .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .reload_wr(reload_wr),
    .reload_val(reload_val), .noise_sel(noise_sel), .duty(duty),
    .trunc_en(trunc_en), .step_pulse(step_pulse), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_level(input bit run, input bit nz,
      input logic [2:0] dt, input logic [2:0] ix, input logic [14:0] lf, input bit tr);
    logic [15:0] v;
    int hc;
    if (!run) v = 16'h0000;
    else if (nz) v = lf[0] ? 16'h8001 : 16'h7FFF;
    else begin
      hc = (dt == 3'd0) ? 1 : int'(dt);
      v = (int'(ix) < hc) ? 16'h7FFF : 16'h8001;
    end
    if (tr) v = v & 16'hFFC0;
    return v;
  endfunction

  function automatic logic [14:0] f_lfsr_next(input logic [14:0] lf);
    return {lf[0] ^ lf[1], lf[14:1]};
  endfunction

  // bench model state
  int          k = -1;
  bit          m_run = 0;
  logic [2:0]  m_idx = 0;
  logic [14:0] m_lfsr = 15'h7FFF;
  bit          pc = 0, pn = 0, pt = 0, p_ready = 0;
  logic [2:0]  pd = 0;
  bit          ev = 0;
  logic [15:0] ed = 0;
  int          b_r = 0;
  bit          fresh = 0, first_pend = 0, have_prev = 0;
  int          start_k = 0, last_k = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      k++;
      if (k > 0) begin
        // R7 / R9: capture and handshake
        if (k % 1024 == 0) begin
          ev = 1;
          ed = f_level(m_run, pn, pd, m_idx, m_lfsr, pt);
          chk(out_valid == 1'b1, "R7 capture valid", int'(out_valid), 1);
          chk(out_data == ed,
              !m_run ? "R6 stopped level" : pt ? "R8 truncated level" :
              pn ? "R5 noise level" : "R4 square level", int'(out_data), int'(ed));
        end else begin
          if (ev && p_ready) ev = 0;
          chk(out_valid == ev, "R9 valid state", int'(out_valid), int'(ev));
          if (ev) chk(out_data == ed, "R9 held data", int'(out_data), int'(ed));
        end
        // model update
        if (pc && !m_run) begin
          m_idx = 0; m_lfsr = 15'h7FFF; start_k = k; have_prev = 0;
          first_pend = fresh; fresh = 0;
          chk(step_pulse == 1'b0, "R3 no step at start", int'(step_pulse), 0);
        end else if (step_pulse) begin
          chk(m_run, "R3 step while stopped", int'(step_pulse), 0);
          m_idx = m_idx + 3'd1;
          m_lfsr = f_lfsr_next(m_lfsr);
          if (first_pend) begin
            chk((k - start_k == 2*(65536-b_r)) || (k - start_k == 2*(65536-b_r)-1),
                "R2 first step after preload", k - start_k, 2*(65536-b_r));
            first_pend = 0;
          end else if (have_prev) begin
            chk(k - last_k == 2*(65536-b_r), "R1 step spacing", k - last_k, 2*(65536-b_r));
          end
          have_prev = 1; last_k = k;
        end
        if (!pc && m_run) begin have_prev = 0; first_pend = 0; end
        m_run = pc;
      end
      pc = ch_start; pn = noise_sel; pd = duty; pt = trunc_en; p_ready = out_ready;
    end
  end

  task automatic run_cycles(input int n, input bit rnd_ready);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (rnd_ready) out_ready = ($urandom % 4) != 0;
    end
  endtask

  task automatic cfg(input logic [15:0] r, input logic [2:0] d, input bit nz, input bit tr);
    @(posedge clk); #1 ch_start = 0;
    repeat (3) begin @(posedge clk); #1; end
    reload_wr = 1; reload_val = r; b_r = int'(r); fresh = 1;
    @(posedge clk); #1 reload_wr = 0;
    duty = d; noise_sel = nz; trunc_en = tr; ch_start = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ch_start = 0; reload_wr = 0; reload_val = 0;
    noise_sel = 0; duty = 0; trunc_en = 0; out_ready = 1;
    @(negedge clk);
    chk(out_valid == 0, "R10 reset valid", int'(out_valid), 0);
    chk(step_pulse == 0, "R10 reset step", int'(step_pulse), 0);
    chk(out_data == 0, "R10 reset data", int'(out_data), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    run_cycles(1500, 0);                  // R6 stopped captures
    cfg(16'hFFF0, 3'd4, 0, 0); run_cycles(3000, 0);   // R4 duty 4
    cfg(16'hFFE8, 3'd0, 0, 0); run_cycles(2100, 0);   // R4 duty 0 as 1
    cfg(16'hFFF3, 3'd7, 0, 1); run_cycles(2100, 0);   // R8 trunc
    cfg(16'hFFE0, 3'd2, 1, 0); run_cycles(4000, 0);   // R5 noise
    @(posedge clk); #1 ch_start = 0; run_cycles(2500, 0);  // R3 stopped
    @(posedge clk); #1 ch_start = 1; run_cycles(1500, 0);  // R3 resume
    out_ready = 0; run_cycles(3000, 0);   // R9 back-pressure
    out_ready = 1; run_cycles(1100, 0);
    cfg(16'hFFFF, 3'd3, 0, 0); run_cycles(1100, 0);   // R1/R2 shortest period
    cfg(16'hFFFE, 3'd5, 1, 1); run_cycles(1100, 0);
    for (int j = 0; j < 8; j++) begin
      cfg(16'hFF00 | 16'($urandom % 256), 3'($urandom % 8),
          1'($urandom % 2), 1'($urandom % 2));
      run_cycles(2500, 1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule